// File: doc/BRIEF.md
# Serializer Power-Down and Lock Sequencer

This block sets the power state of a serial link transmitter. A power-enable pin and a flag that reports the input supply together decide whether the transmitter is on. While either one is low, the PLL is stopped, the internal termination is out and the serial output floats. Once both are high, the PLL is enabled and the termination is switched in, so the output sits at zero differential. A lock counter then runs on the parallel clock. When it completes, the output driver is enabled. Dropping the enable at any time returns the block to the off state in the same cycle and discards the count.

The block also decodes the clock-range pins into a one-hot band select. It checks the modulation pins against the range. A reserved modulation code, or the large modulation step combined with one of the two low clock bands, raises a configuration error and forces modulation off.

Top module: `pwr_lock_seq`

## Requirements
- R1: While `rst_n` is low, `pll_en_o`, `term_en_o`, `drv_en_o` and `cfg_err_o` are 0, `out_hiz_o` is 1, `band_o` is 4'b0001 and `mod_eff_o` is 2'b00.
- R2: In any cycle in which `pwr_pin_i` is 0, `pll_en_o`, `term_en_o` and `drv_en_o` are 0 and `out_hiz_o` is 1, with no clock edge needed.
- R3: When `supply_ok_i` is 0, the outputs are the same as under R2 whatever the value of `pwr_pin_i`.
- R4: When `pwr_pin_i` and `supply_ok_i` are both 1 and the lock count is not complete, `pll_en_o` and `term_en_o` are 1, `out_hiz_o` is 1 and `drv_en_o` is 0 (terminated idle).
- R5: After exactly `LOCK_CYCLES` (default 16385) rising clock edges with the enable held high, `drv_en_o` becomes 1 and `out_hiz_o` becomes 0. After one edge fewer, the output is still idle.
- R6: A drop of the enable during counting clears the count. After the enable returns, a full `LOCK_CYCLES` edges are needed again.
- R7: A drop of the enable after lock returns the outputs to the R2 state in the same cycle. Re-enabling then needs a full lock count.
- R8: One edge after `rng_sel_i` is applied, `band_o` has exactly one bit set: bit 0 for code 0, bit 1 for code 1, bit 2 for code 2, bit 3 for code 3.
- R9: Modulation code 00 (off) and code 01 (small step) pass unchanged to `mod_eff_o` in any band. Code 10 (large step) passes when the range code is 2 or 3. In these cases `cfg_err_o` is 0, one edge after the inputs are applied.
- R10: Modulation code 11 is reserved. One edge after it is applied, `cfg_err_o` is 1 and `mod_eff_o` is 00.
- R11: Modulation code 10 with range code 0 or 1 gives `cfg_err_o` = 1 and `mod_eff_o` = 00, one edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel clock; the lock count runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_pin_i | input | 1 | Power enable pin; low requests power-down |
| supply_ok_i | input | 1 | Input supply present; low forces power-down |
| rng_sel_i | input | 2 | Parallel clock range code |
| mod_sel_i | input | 2 | Phase-modulation step code |
| pll_en_o | output | 1 | PLL run enable |
| term_en_o | output | 1 | Internal termination switched in |
| out_hiz_o | output | 1 | Serial output at high impedance |
| drv_en_o | output | 1 | Serial output driver enabled |
| band_o | output | 4 | One-hot clock band select |
| mod_eff_o | output | 2 | Modulation code actually applied |
| cfg_err_o | output | 1 | Illegal range/modulation combination |

## Verification
The hardest case to reach is an abort that lands deep inside the lock window and is then followed by a complete second count. A shortened count would pass any check that looks only near the moment of lock. The stimulus holds the enable for a thousand edges, drops it for a single edge, and then re-raises it. It samples the driver one edge before and exactly at the full lock count. The same two-sided sampling is used after a supply loss with the pin still high, and again after a drop that follows lock.

// File: rtl/lps_pkg.sv
package lps_pkg;

   typedef enum logic [1:0] {
      OM_HIZ   = 2'd0,
      OM_IDLE  = 2'd1,
      OM_DRIVE = 2'd2
   } out_mode_e;

   localparam logic [1:0] MOD_OFF   = 2'b00;
   localparam logic [1:0] MOD_SMALL = 2'b01;
   localparam logic [1:0] MOD_LARGE = 2'b10;
   localparam logic [1:0] MOD_RSVD  = 2'b11;

endpackage

// File: rtl/lps_lock_counter.sv
module lps_lock_counter #(
   parameter int LOCK_CYCLES = 16385,
   parameter int CNT_W       = $clog2(LOCK_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic done_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_CYCLES);

   logic [CNT_W-1:0] cnt_q;

   // the count restarts from zero whenever the enable is seen low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en_i) begin
         cnt_q <= '0;
      end else if (cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/lps_out_ctrl.sv
module lps_out_ctrl
   import lps_pkg::*;
(
   input  logic en_i,
   input  logic lock_done_i,
   output logic pll_en_o,
   output logic term_en_o,
   output logic out_hiz_o,
   output logic drv_en_o
);
   out_mode_e mode;

   always_comb begin
      if (!en_i)             mode = OM_HIZ;
      else if (lock_done_i)  mode = OM_DRIVE;
      else                   mode = OM_IDLE;
   end

   always_comb begin
      pll_en_o  = 1'b0;
      term_en_o = 1'b0;
      out_hiz_o = 1'b1;
      drv_en_o  = 1'b0;
      case (mode)
         OM_IDLE: begin
            pll_en_o  = 1'b1;
            term_en_o = 1'b1;
         end
         OM_DRIVE: begin
            pll_en_o  = 1'b1;
            term_en_o = 1'b1;
            out_hiz_o = 1'b0;
            drv_en_o  = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/lps_cfg_decode.sv
module lps_cfg_decode
   import lps_pkg::*;
#(
   parameter int RNG_W            = 2,
   parameter int BIG_STEP_MIN_RNG = 2,
   parameter bit REG_OUT          = 1'b1,
   parameter int NUM_BANDS        = 1 << RNG_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [RNG_W-1:0]     rng_i,
   input  logic [1:0]           mod_i,
   output logic [NUM_BANDS-1:0] band_o,
   output logic [1:0]           mod_eff_o,
   output logic                 cfg_err_o
);
   localparam logic [RNG_W-1:0] RNG_MIN = RNG_W'(BIG_STEP_MIN_RNG);

   logic [NUM_BANDS-1:0] band_c;
   logic [1:0]           mod_c;
   logic                 err_c;

   for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
      assign band_c[b] = (rng_i == RNG_W'(b));
   end

   always_comb begin
      err_c = (mod_i == MOD_RSVD) ||
              ((mod_i == MOD_LARGE) && (rng_i < RNG_MIN));
      mod_c = err_c ? MOD_OFF : mod_i;
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            band_o    <= NUM_BANDS'(1);
            mod_eff_o <= MOD_OFF;
            cfg_err_o <= 1'b0;
         end else begin
            band_o    <= band_c;
            mod_eff_o <= mod_c;
            cfg_err_o <= err_c;
         end
      end
   end else begin : g_comb
      assign band_o    = rst_n ? band_c : NUM_BANDS'(1);
      assign mod_eff_o = rst_n ? mod_c  : MOD_OFF;
      assign cfg_err_o = rst_n & err_c;
   end
endmodule

// File: rtl/pwr_lock_seq.sv
module pwr_lock_seq #(
   parameter int LOCK_CYCLES      = 16385,
   parameter int RNG_W            = 2,
   parameter int BIG_STEP_MIN_RNG = 2,
   parameter bit REG_SETTINGS     = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pwr_pin_i,
   input  logic                     supply_ok_i,
   input  logic [RNG_W-1:0]         rng_sel_i,
   input  logic [1:0]               mod_sel_i,
   output logic                     pll_en_o,
   output logic                     term_en_o,
   output logic                     out_hiz_o,
   output logic                     drv_en_o,
   output logic [(1<<RNG_W)-1:0]    band_o,
   output logic [1:0]               mod_eff_o,
   output logic                     cfg_err_o
);
   localparam int NUM_BANDS = 1 << RNG_W;
   localparam int CNT_W     = $clog2(LOCK_CYCLES + 1);

   if (LOCK_CYCLES < 2) begin : g_bad_lock
      $error("LOCK_CYCLES must be at least 2");
   end
   if (BIG_STEP_MIN_RNG >= NUM_BANDS) begin : g_bad_rng
      $error("BIG_STEP_MIN_RNG must name an existing band");
   end

   logic en_req;
   logic lock_done;

   // missing supply overrides the pin; reset also holds power off
   assign en_req = pwr_pin_i & supply_ok_i & rst_n;

   lps_lock_counter #(
      .LOCK_CYCLES (LOCK_CYCLES),
      .CNT_W       (CNT_W)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en_req),
      .done_o (lock_done)
   );

   lps_out_ctrl u_out (
      .en_i        (en_req),
      .lock_done_i (lock_done),
      .pll_en_o    (pll_en_o),
      .term_en_o   (term_en_o),
      .out_hiz_o   (out_hiz_o),
      .drv_en_o    (drv_en_o)
   );

   lps_cfg_decode #(
      .RNG_W            (RNG_W),
      .BIG_STEP_MIN_RNG (BIG_STEP_MIN_RNG),
      .REG_OUT          (REG_SETTINGS),
      .NUM_BANDS        (NUM_BANDS)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .rng_i     (rng_sel_i),
      .mod_i     (mod_sel_i),
      .band_o    (band_o),
      .mod_eff_o (mod_eff_o),
      .cfg_err_o (cfg_err_o)
   );
endmodule

// File: rtl/pwr_lock_seq_chk.sv
module pwr_lock_seq_chk #(
   parameter int LOCK_CYCLES      = 16385,
   parameter int RNG_W            = 2,
   parameter int BIG_STEP_MIN_RNG = 2,
   parameter bit REG_SETTINGS     = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  pwr_pin_i,
   input logic                  supply_ok_i,
   input logic [RNG_W-1:0]      rng_sel_i,
   input logic [1:0]            mod_sel_i,
   input logic                  pll_en_o,
   input logic                  term_en_o,
   input logic                  out_hiz_o,
   input logic                  drv_en_o,
   input logic [(1<<RNG_W)-1:0] band_o,
   input logic [1:0]            mod_eff_o,
   input logic                  cfg_err_o
);
   localparam int W = $clog2(LOCK_CYCLES + 1);
   localparam logic [W-1:0] WIN = W'(LOCK_CYCLES);

   logic       en_seen;
   logic [W-1:0] run_q;

   assign en_seen = pwr_pin_i & supply_ok_i;

   // consecutive enabled edges, used to check the lock window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_q <= '0;
      else if (!en_seen) run_q <= '0;
      else if (run_q != WIN) run_q <= run_q + 1'b1;
   end

   // R2
   pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_pin_i |-> (!pll_en_o && !term_en_o && out_hiz_o && !drv_en_o));

   // R3
   supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok_i |-> (!pll_en_o && !term_en_o && out_hiz_o && !drv_en_o));

   // R4
   idle_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_seen && !drv_en_o) |-> (pll_en_o && term_en_o && out_hiz_o));

   // R5
   lock_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en_o |-> (run_q == WIN && !out_hiz_o));

   // R6
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_seen |=> !drv_en_o);

   // R8
   band_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(band_o) == 1);

   // R10
   err_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |-> (mod_eff_o == 2'b00));

   if (REG_SETTINGS) begin : g_reg_chk
      // R11
      low_band_large_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(mod_sel_i == 2'b10) &&
          $past(rng_sel_i < RNG_W'(BIG_STEP_MIN_RNG))) |-> cfg_err_o);
   end else begin : g_comb_chk
      // R11
      low_band_large_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mod_sel_i == 2'b10 && rng_sel_i < RNG_W'(BIG_STEP_MIN_RNG)) |-> cfg_err_o);
   end
endmodule

bind pwr_lock_seq pwr_lock_seq_chk #(
   .LOCK_CYCLES      (LOCK_CYCLES),
   .RNG_W            (RNG_W),
   .BIG_STEP_MIN_RNG (BIG_STEP_MIN_RNG),
   .REG_SETTINGS     (REG_SETTINGS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwr_pin_i   (pwr_pin_i),
   .supply_ok_i (supply_ok_i),
   .rng_sel_i   (rng_sel_i),
   .mod_sel_i   (mod_sel_i),
   .pll_en_o    (pll_en_o),
   .term_en_o   (term_en_o),
   .out_hiz_o   (out_hiz_o),
   .drv_en_o    (drv_en_o),
   .band_o      (band_o),
   .mod_eff_o   (mod_eff_o),
   .cfg_err_o   (cfg_err_o)
);

// File: tb/sim_pwr_lock_seq.sv
`timescale 1ns/100ps
module sim_pwr_lock_seq;
   localparam int LOCK = 16385;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_pin_i = 1'b0;
   logic       supply_ok_i = 1'b1;
   logic [1:0] rng_sel_i = 2'b00;
   logic [1:0] mod_sel_i = 2'b00;
   logic       pll_en_o, term_en_o, out_hiz_o, drv_en_o, cfg_err_o;
   logic [3:0] band_o;
   logic [1:0] mod_eff_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pwr_lock_seq u0 (
      .clk(clk), .rst_n(rst_n), .pwr_pin_i(pwr_pin_i), .supply_ok_i(supply_ok_i),
      .rng_sel_i(rng_sel_i), .mod_sel_i(mod_sel_i), .pll_en_o(pll_en_o),
      .term_en_o(term_en_o), .out_hiz_o(out_hiz_o), .drv_en_o(drv_en_o),
      .band_o(band_o), .mod_eff_o(mod_eff_o), .cfg_err_o(cfg_err_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // pack {pll, term, hiz, drv}
   function automatic logic [31:0] outs();
      return {28'd0, pll_en_o, term_en_o, out_hiz_o, drv_en_o};
   endfunction

   localparam logic [31:0] ST_OFF   = 32'b0010;
   localparam logic [31:0] ST_IDLE  = 32'b1110;
   localparam logic [31:0] ST_DRIVE = 32'b1101;

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      rng_sel_i = 2'b11; mod_sel_i = 2'b11; pwr_pin_i = 1'b1;
      tick(2);
      #1;
      chk("R1 outputs in reset", outs(), ST_OFF);
      chk("R1 band in reset", {28'd0, band_o}, 32'h1);
      chk("R1 mod/err in reset", {29'd0, mod_eff_o, cfg_err_o}, 32'h0);
      pwr_pin_i = 1'b0; rng_sel_i = 2'b00; mod_sel_i = 2'b00;
      rst_n = 1'b1;
      tick(2);
      chk("R2 pin low after reset", outs(), ST_OFF);
   endtask

   task automatic t_bands();
      for (int r = 0; r < 4; r++) begin
         rng_sel_i = 2'(r);
         tick(1);
         chk($sformatf("R8 band code %0d", r), {28'd0, band_o}, 32'd1 << r);
      end
   endtask

   task automatic t_mod_pass();
      rng_sel_i = 2'b00; mod_sel_i = 2'b01; tick(1);
      chk("R9 small step low band", {29'd0, mod_eff_o, cfg_err_o}, {29'd0, 2'b01, 1'b0});
      mod_sel_i = 2'b00; tick(1);
      chk("R9 off", {29'd0, mod_eff_o, cfg_err_o}, 32'h0);
      rng_sel_i = 2'b10; mod_sel_i = 2'b10; tick(1);
      chk("R9 large step band 2", {29'd0, mod_eff_o, cfg_err_o}, {29'd0, 2'b10, 1'b0});
      rng_sel_i = 2'b11; tick(1);
      chk("R9 large step band 3", {29'd0, mod_eff_o, cfg_err_o}, {29'd0, 2'b10, 1'b0});
   endtask

   task automatic t_mod_rsvd();
      rng_sel_i = 2'b11; mod_sel_i = 2'b11; tick(1);
      chk("R10 reserved code", {29'd0, mod_eff_o, cfg_err_o}, 32'h1);
      mod_sel_i = 2'b01; tick(1);
      chk("R10 error clears", {29'd0, mod_eff_o, cfg_err_o}, {29'd0, 2'b01, 1'b0});
   endtask

   task automatic t_mod_low_band();
      for (int r = 0; r < 2; r++) begin
         rng_sel_i = 2'(r); mod_sel_i = 2'b10; tick(1);
         chk($sformatf("R11 large step band %0d", r), {29'd0, mod_eff_o, cfg_err_o}, 32'h1);
      end
      mod_sel_i = 2'b00; tick(1);
   endtask

   task automatic t_lock_basic();
      pwr_pin_i = 1'b1;
      #1;
      chk("R4 idle immediately", outs(), ST_IDLE);
      tick(LOCK - 1);
      chk("R5 one edge before lock", outs(), ST_IDLE);
      tick(1);
      chk("R5 driven at lock", outs(), ST_DRIVE);
      tick(5);
      chk("R5 stays driven", outs(), ST_DRIVE);
      pwr_pin_i = 1'b0;
      #1;
      chk("R7 drop after lock same cycle", outs(), ST_OFF);
      tick(1);
      pwr_pin_i = 1'b1;
      tick(LOCK - 1);
      chk("R7 relock needs full count", outs(), ST_IDLE);
      tick(1);
      chk("R7 relocked", outs(), ST_DRIVE);
   endtask

   task automatic t_abort();
      pwr_pin_i = 1'b0; tick(1);
      pwr_pin_i = 1'b1; tick(1000);
      chk("R6 counting idle", outs(), ST_IDLE);
      pwr_pin_i = 1'b0;
      #1;
      chk("R6 abort off same cycle", outs(), ST_OFF);
      tick(1);
      pwr_pin_i = 1'b1;
      tick(LOCK - 1);
      chk("R6 no early lock after abort", outs(), ST_IDLE);
      tick(1);
      chk("R6 lock after full recount", outs(), ST_DRIVE);
   endtask

   task automatic t_supply();
      supply_ok_i = 1'b0;
      #1;
      chk("R3 supply loss overrides pin", outs(), ST_OFF);
      tick(3);
      chk("R3 stays off with pin high", outs(), ST_OFF);
      supply_ok_i = 1'b1;
      #1;
      chk("R3 supply back idle", outs(), ST_IDLE);
      tick(LOCK - 1);
      chk("R3 no early lock", outs(), ST_IDLE);
      tick(1);
      chk("R3 lock after supply return", outs(), ST_DRIVE);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_bands();
      t_mod_pass();
      t_mod_rsvd();
      t_mod_low_band();
      t_lock_basic();
      t_abort();
      t_supply();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(5ns * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule